// File: doc/BRIEF.md
# Single-Cycle Accumulator Processor Core with Conditional Branch

This block is a 16-bit processor core that completes one instruction on every clock edge. The program counter drives an external read-only instruction store, and the word that comes back is the current instruction. A separate data memory is read combinationally and written on the clock edge. The core holds two working registers. The data register supplies the first ALU operand. The address register serves three purposes: it is the data memory address, it is the branch target, and it can be the second ALU operand.

There are two instruction kinds. An address-load instruction puts a 15-bit constant into the address register. A compute instruction does three things: it picks the second operand, it selects an ALU function, it routes the result to any mix of address register, data register and memory. It can also redirect the program counter. The branch decision tests the sign and zero of the ALU result computed in the same cycle, so the next PC is known at the edge that retires the instruction.

The reset input is asynchronous and active low. It is released through a two-stage synchronizer, so the core leaves reset on a clock edge.

Top module: `acc_cpu`

## Requirements
- R1: While `rst_n` is low, `pc_o` reads 0. Once `rst_n` has been high for three rising edges, the PC advances on every edge.
- R2: An instruction with bit 15 = 0 is an address-load. It writes bits 14:0 into the address register, with bit 15 of that register cleared. It never asserts `mem_we_o`, whatever its other bits are.
- R3: An instruction with bit 15 = 1 is a compute instruction. In a compute instruction, bit 12 picks the second ALU operand: 0 selects the address register and 1 selects `mem_rdata_i`. The first operand is always the data register.
- R4: Bits 11:6 set the ALU function, from bit 11 down to bit 6:
  - zero the first operand;
  - invert the first operand;
  - zero the second operand;
  - invert the second operand;
  - choose add (1) or bitwise AND (0);
  - invert the result.
- R5: In a compute instruction, bit 5 writes the result to the address register, bit 4 writes it to the data register, and bit 3 writes it to memory. `mem_wdata_o` always carries the ALU result. `mem_we_o` is high only when bit 15 and bit 3 are both set.
- R6: `mem_addr_o` equals bits 14:0 of the address register at all times, including after the register has been loaded with a full 16-bit ALU result.
- R7: In a compute instruction, bit 2 branches if the result is negative, bit 1 branches if it is zero, and bit 0 branches if it is positive. If any selected condition holds, the next PC is bits 14:0 of the address register as it stood before the edge. Otherwise the next PC is PC+1.
- R8: An address-load instruction, and a compute instruction with bits 2:0 = 000, always advance the PC by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| instr_i | input | 16 | Current instruction from the instruction store |
| mem_rdata_i | input | 16 | Data memory read word at `mem_addr_o` |
| mem_wdata_o | output | 16 | ALU result, written to memory when enabled |
| mem_we_o | output | 1 | Data memory write enable |
| mem_addr_o | output | 15 | Data memory address |
| pc_o | output | 15 | Program counter, the instruction store address |

## Verification
The assertions run on every cycle. They check that each PC step is either an increment or a move to the address register, that non-branching instructions always increment, and that the always-taken code always takes the branch. They also check that address-loads land in the address register, that the write enable never rises for an address-load, and that the ALU never reports negative and zero together. Only the bench scenarios can show the arithmetic of all 64 ALU function codes across both operand sources, and that each of the eight jump codes is taken or skipped correctly against negative, zero and positive results. The same holds for the wrap from a 16-bit result down to a 15-bit address, and for the release timing of reset.

// File: rtl/acc_pkg.sv
`timescale 1ns/1ps
package acc_pkg;
  localparam int unsigned DW = 16;
  localparam int unsigned AW = 15;

  localparam int unsigned B_KIND  = 15;
  localparam int unsigned B_SEL   = 12;
  localparam int unsigned B_FN_HI = 11;
  localparam int unsigned B_FN_LO = 6;
  localparam int unsigned B_WR_A  = 5;
  localparam int unsigned B_WR_D  = 4;
  localparam int unsigned B_WR_M  = 3;

  typedef struct packed {
    logic       cx;   // zero first operand
    logic       ix;   // invert first operand
    logic       cy;   // zero second operand
    logic       iy;   // invert second operand
    logic       add;  // add instead of AND
    logic       io;   // invert result
  } alu_fn_t;

  typedef struct packed {
    logic          is_comp;
    logic          sel_mem;
    alu_fn_t       fn;
    logic          wr_a;
    logic          wr_d;
    logic          wr_m;
    logic [2:0]    jmp;   // {neg, zero, pos}
    logic [AW-1:0] imm;
  } dec_t;
endpackage

// File: rtl/acc_decode.sv
`timescale 1ns/1ps
module acc_decode
  import acc_pkg::*;
(
  input  logic [DW-1:0] instr,
  output dec_t          dec
);
  always_comb begin
    dec.is_comp = instr[B_KIND];
    dec.sel_mem = instr[B_KIND] & instr[B_SEL];
    dec.fn      = alu_fn_t'(instr[B_FN_HI:B_FN_LO]);
    dec.wr_a    = instr[B_KIND] & instr[B_WR_A];
    dec.wr_d    = instr[B_KIND] & instr[B_WR_D];
    dec.wr_m    = instr[B_KIND] & instr[B_WR_M];
    dec.jmp     = instr[B_KIND] ? instr[2:0] : 3'b000;
    dec.imm     = instr[AW-1:0];
  end
endmodule

// File: rtl/acc_alu.sv
`timescale 1ns/1ps
module acc_alu
  import acc_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic [W-1:0] op_x,
  input  logic [W-1:0] op_y,
  input  alu_fn_t      fn,
  output logic [W-1:0] res,
  output logic         is_zero,
  output logic         is_neg
);
  logic [W-1:0] x0, x1, y0, y1, raw;

  always_comb begin
    x0      = fn.cx ? '0 : op_x;
    x1      = fn.ix ? ~x0 : x0;
    y0      = fn.cy ? '0 : op_y;
    y1      = fn.iy ? ~y0 : y0;
    raw     = fn.add ? (x1 + y1) : (x1 & y1);
    res     = fn.io ? ~raw : raw;
    is_zero = (res == '0);
    is_neg  = res[W-1];
  end

  // R7: flags used by the branch unit are mutually exclusive
  always_comb begin
    AST_FLAGS_EXCL: assert (!(is_zero && is_neg)); // R7
  end
endmodule

// File: rtl/acc_pc.sv
`timescale 1ns/1ps
module acc_pc
  import acc_pkg::*;
#(
  parameter int unsigned PW = AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    jmp,
  input  logic          is_zero,
  input  logic          is_neg,
  input  logic [PW-1:0] target,
  output logic [PW-1:0] pc
);
  logic          take;
  logic [PW-1:0] pc_d;

  always_comb begin
    take = (jmp[2] & is_neg) |
           (jmp[1] & is_zero) |
           (jmp[0] & ~is_neg & ~is_zero);
    pc_d = take ? target : (pc + PW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc <= '0;
    else        pc <= pc_d;
  end

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pc == $past(pc) + PW'(1)) || (pc == $past(target))); // R7

  AST_NO_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    (jmp == 3'b000) |=> (pc == $past(pc) + PW'(1))); // R8

  AST_JUMP_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (jmp == 3'b111) |=> (pc == $past(target))); // R7
endmodule

// File: rtl/acc_cpu.sv
`timescale 1ns/1ps
module acc_cpu
  import acc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [15:0]   instr_i,
  input  logic [15:0]   mem_rdata_i,
  output logic [15:0]   mem_wdata_o,
  output logic          mem_we_o,
  output logic [14:0]   mem_addr_o,
  output logic [14:0]   pc_o
);
  logic [1:0]    rst_sync;
  logic          core_rst_n;
  dec_t          dec;
  logic [DW-1:0] a_q, a_d, d_q, d_d;
  logic          a_en, d_en;
  logic [DW-1:0] alu_y, alu_res;
  logic          alu_zero, alu_neg;

  // reset: asserted at once, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign core_rst_n = rst_sync[1];

  acc_decode u_dec (
    .instr (instr_i),
    .dec   (dec)
  );

  assign alu_y = dec.sel_mem ? mem_rdata_i : a_q;

  acc_alu #(.W(DW)) u_alu (
    .op_x    (d_q),
    .op_y    (alu_y),
    .fn      (dec.fn),
    .res     (alu_res),
    .is_zero (alu_zero),
    .is_neg  (alu_neg)
  );

  acc_pc #(.PW(AW)) u_pc (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .jmp     (dec.jmp),
    .is_zero (alu_zero),
    .is_neg  (alu_neg),
    .target  (a_q[AW-1:0]),
    .pc      (pc_o)
  );

  // next-state for working registers
  always_comb begin
    a_en = ~dec.is_comp | dec.wr_a;
    a_d  = dec.is_comp ? alu_res : {{(DW-AW){1'b0}}, dec.imm};
    d_en = dec.wr_d;
    d_d  = alu_res;
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      a_q <= '0;
      d_q <= '0;
    end else begin
      if (a_en) a_q <= a_d;
      if (d_en) d_q <= d_d;
    end
  end

  assign mem_wdata_o = alu_res;
  assign mem_we_o    = dec.wr_m;
  assign mem_addr_o  = a_q[AW-1:0];

  AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (!core_rst_n)
    !instr_i[15] |=> (a_q == {1'b0, $past(instr_i[14:0])})); // R2

  AST_WE_KIND: assert property (@(posedge clk) disable iff (!core_rst_n)
    mem_we_o |-> instr_i[15]); // R5

  AST_ADDR_TRACKS: assert property (@(posedge clk) disable iff (!core_rst_n)
    (instr_i[15] && instr_i[5]) |=> (mem_addr_o == $past(mem_wdata_o[14:0]))); // R6
endmodule

// File: tb/sim_acc_cpu.sv
`timescale 1ns/1ps
module sim_acc_cpu;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] instr_i;
  logic [15:0] mem_rdata_i;
  logic [15:0] mem_wdata_o;
  logic        mem_we_o;
  logic [14:0] mem_addr_o;
  logic [14:0] pc_o;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  acc_cpu u0 (
    .clk(clk), .rst_n(rst_n), .instr_i(instr_i), .mem_rdata_i(mem_rdata_i),
    .mem_wdata_o(mem_wdata_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .pc_o(pc_o)
  );

  localparam logic [5:0] F_PASS_Y = 6'b110000;
  localparam logic [5:0] F_PASS_X = 6'b001100;

  function automatic logic [15:0] alu_model(input logic [15:0] x, input logic [15:0] y,
                                            input logic [5:0] f);
    logic [15:0] a, b, r;
    a = f[5] ? 16'd0 : x;
    if (f[4]) a = 16'hFFFF - a;
    b = f[3] ? 16'd0 : y;
    if (f[2]) b = 16'hFFFF - b;
    r = f[1] ? 16'(a + b) : (a & b);
    if (f[0]) r = 16'hFFFF - r;
    return r;
  endfunction

  function automatic logic [15:0] comp(input logic sel, input logic [5:0] f,
                                       input logic [2:0] dst, input logic [2:0] j);
    return {1'b1, 2'b11, sel, f, dst, j};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [15:0] ins, input logic [15:0] rd);
    instr_i = ins;
    mem_rdata_i = rd;
    @(posedge clk); #1;
  endtask

  task automatic set_d(input logic [15:0] v);
    step(comp(1'b1, F_PASS_Y, 3'b010, 3'b000), v);
  endtask

  task automatic set_a(input logic [15:0] v);
    step(comp(1'b1, F_PASS_Y, 3'b100, 3'b000), v);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] dv [4] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h1234};
    logic [15:0] av [4] = '{16'h0000, 16'hFFFF, 16'h0001, 16'hFF00};
    logic [15:0] mv [4] = '{16'h5555, 16'h8000, 16'hFFFF, 16'h00F0};
    logic [14:0] p0;
    rst_n = 1'b0;
    instr_i = 16'h0000;
    mem_rdata_i = 16'h0000;
    repeat (3) @(posedge clk);
    #1;
    check("R1 pc in reset", pc_o, 0);
    check("R2 we idle", mem_we_o, 0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    p0 = pc_o;
    @(posedge clk); #1;
    check("R1 advance after release", pc_o, 15'(p0 + 1));

    // R2 / R6 / R8: address-load with compute-like low bits
    p0 = pc_o;
    instr_i = 16'h7FFF; #1;
    check("R2 no write on load", mem_we_o, 0);
    @(posedge clk); #1;
    check("R2 A loaded", mem_addr_o, 15'h7FFF);
    check("R8 load no jump", pc_o, 15'(p0 + 1));
    step(16'h0123, 0);
    check("R6 addr follows A", mem_addr_o, 15'h0123);
    set_a(16'hFFFF);
    check("R6 16-bit A drops bit 15", mem_addr_o, 15'h7FFF);

    // R5: destination and write enable
    set_d(16'hBEEF);
    instr_i = comp(1'b0, F_PASS_X, 3'b010, 3'b000); #1;
    check("R5 we low for D dest", mem_we_o, 0);
    instr_i = comp(1'b0, F_PASS_X, 3'b001, 3'b000); #1;
    check("R5 we high for M dest", mem_we_o, 1);
    check("R5 D written", mem_wdata_o, 16'hBEEF);
    instr_i = comp(1'b0, F_PASS_X, 3'b100, 3'b000);
    @(posedge clk); #1;
    check("R5 A written", mem_addr_o, 15'h3EEF);

    // R3 / R4: ALU sweep across all functions and both operand sources
    for (int p = 0; p < 4; p++) begin
      for (int s = 0; s < 2; s++) begin
        for (int f = 0; f < 64; f++) begin
          set_d(dv[p]);
          set_a(av[p]);
          instr_i = comp(s[0], f[5:0], 3'b001, 3'b000);
          mem_rdata_i = mv[p];
          #2;
          check(s ? "R3 R4 operand mem" : "R3 R4 operand A", mem_wdata_o,
                alu_model(dv[p], s ? mv[p] : av[p], f[5:0]));
          @(posedge clk); #1;
        end
      end
    end

    // R7 / R8: every jump code against negative, zero, positive
    for (int v = 0; v < 3; v++) begin
      for (int j = 0; j < 8; j++) begin
        logic [15:0] val;
        logic tk;
        val = (v == 0) ? 16'hFFFB : ((v == 1) ? 16'h0000 : 16'h0007);
        set_d(val);
        step(16'h0100 + 16'(j * 3 + v), 0);
        p0 = pc_o;
        tk = (j[2] && v == 0) || (j[1] && v == 1) || (j[0] && v == 2);
        step(comp(1'b0, F_PASS_X, 3'b000, j[2:0]), 0);
        check(j == 0 ? "R8 no-jump code" : "R7 jump decision", pc_o,
              tk ? 15'(16'h0100 + 16'(j * 3 + v)) : 15'(p0 + 1));
      end
    end

    // R1: reset mid-run
    rst_n = 1'b0; #1;
    check("R1 async reset", pc_o, 0);
    @(posedge clk); #1;
    check("R1 held in reset", pc_o, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule